// File: doc/BRIEF.md
# Command Stream Header Decoder

This block sits at the front of a copy engine and turns a stream of 32-bit command words into register-write strobes. A header word says where the writes go (a subchannel number and a method address) and how many data words follow. Each of those data words leaves the block as one write carrying the subchannel, the byte method address and the word itself. When the data words are used up, the next input word is read as a new header.

Two header layouts are supported. A static mode input selects which one applies. The older layout carries the method as a byte address and offers both incrementing and non-incrementing packets. The newer layout carries the method in 32-bit word units and offers incrementing packets only. In an incrementing packet, successive data words target successive methods 4 bytes apart. In a non-incrementing packet, every data word targets the same method. A typical use is binding an object handle to the copy engine's subchannel 6 through method 0, followed by incrementing bursts of parameter writes.

The input is a valid/ready word stream. The output is a write strobe with its own ready. A data word is consumed only in the cycle its write is accepted, so output backpressure holds the input. Header words are consumed without touching the output.

Top module: `cmdStreamDecoder`

## Requirements
- R1: After reset, wrValid is 0, inReady is 1 (the block expects a header) and errSticky is 0.
- R2: With newLayout = 0, the count is bits 28:18, the subchannel is bits 15:13 and the byte method address is bits 12:0 with bits 1:0 forced to zero. Bits 31:30 = 00 select an incrementing packet.
- R3: With newLayout = 0 and bits 31:30 = 01, the packet is non-incrementing: every data word of the packet is written to the method address given in the header.
- R4: With newLayout = 1, bits 31:29 = 001 mark an incrementing header. The count is bits 28:16, the subchannel is bits 15:13, and bits 12:0 give the method in 32-bit word units, so the byte address is that value times 4.
- R5: In an incrementing packet, data word k (counting from 0) targets the header byte address plus 4·k, modulo 2^15 (the byte address is 15 bits wide).
- R6: A header with count N > 0 produces exactly N writes. Each write carries the data word unchanged and the header's subchannel. The word after the N-th data word is decoded as a header.
- R7: A header with count 0 produces no write, and the next word is decoded as a header.
- R8: A header with an unrecognised top-bit pattern is treated as follows. In the older layout this is bit 31 = 1. In the newer layout it is bits 31:29 ≠ 001. The word is dropped without any write, errSticky goes to 1 and stays 1 until reset, and the next word is decoded as a header.
- R9: While a data write is pending and wrReady is 0, inReady is 0 and the write's subchannel, method and data stay unchanged. A header word is accepted (inReady = 1) whatever the value of wrReady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| newLayout | input | 1 | Static header layout select: 0 older, 1 newer |
| inValid | input | 1 | Input word valid |
| inReady | output | 1 | Input word accepted this cycle when inValid is high |
| inWord | input | 32 | Command stream word |
| wrValid | output | 1 | Register-write strobe valid |
| wrReady | input | 1 | Consumer accepts the write |
| wrSubch | output | 3 | Target subchannel |
| wrMethod | output | 15 | Target byte method address |
| wrData | output | 32 | Data word to write |
| errSticky | output | 1 | Set by an unrecognised header, cleared by reset |

## Verification
The bench sweeps every subchannel, several counts including zero and each packet kind in both layouts, and computes each expected method address arithmetically. This catches a field taken from the wrong bit range or a missing times-4 scaling in the newer layout. A method that wraps at the top of the 15-bit space, and low address bits set in an older header, expose a wrong address width or unmasked low bits. Zero-count and malformed headers are followed directly by a header. A decoder that treats count 0 as a large count, or that takes the word after a bad header as data, would emit spurious writes. Stalls of several cycles in the middle of packets show whether a decoder drops or repeats a data word under backpressure, or lets the address move while the write is held.

// File: rtl/cmdDecPkg.sv
package cmdDecPkg;
  localparam int WORD_W  = 32;
  localparam int SUB_W   = 3;
  localparam int CNT_W   = 13;
  localparam int METH_W  = 15;
  localparam int FIELD_W = 13;

  typedef struct packed {
    logic loadHdr;
    logic advance;
    logic flagBad;
  } ctlStrobeT;

  typedef struct packed {
    logic             bad;
    logic             nonInc;
    logic [CNT_W-1:0] count;
  } hdrInfoT;
endpackage

// File: rtl/cmdDecPath.sv
module cmdDecPath
  import cmdDecPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              newLayout,
  input  logic [WORD_W-1:0] inWord,
  input  ctlStrobeT         ctl,
  output hdrInfoT           hdr,
  output logic [SUB_W-1:0]  wrSubch,
  output logic [METH_W-1:0] wrMethod,
  output logic              errSticky
);
  logic [METH_W-1:0] hdrMeth;
  logic [METH_W-1:0] methReg;
  logic [SUB_W-1:0]  subReg;
  logic              nonIncReg;
  logic              errReg;

  always_comb begin
    hdr     = '0;
    hdrMeth = '0;
    if (!newLayout) begin
      hdr.count  = CNT_W'(inWord[28:18]);
      hdr.nonInc = inWord[30];
      hdr.bad    = inWord[31];
      hdrMeth    = METH_W'({inWord[FIELD_W-1:2], 2'b00});
    end else begin
      hdr.count  = inWord[28:16];
      hdr.nonInc = 1'b0;
      hdr.bad    = (inWord[31:29] != 3'b001);
      hdrMeth    = METH_W'({inWord[FIELD_W-1:0], 2'b00});
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      methReg   <= '0;
      subReg    <= '0;
      nonIncReg <= 1'b0;
      errReg    <= 1'b0;
    end else begin
      if (ctl.loadHdr) begin
        methReg   <= hdrMeth;
        subReg    <= inWord[15:13];
        nonIncReg <= hdr.nonInc;
      end else if (ctl.advance && !nonIncReg) begin
        methReg <= methReg + METH_W'(4);
      end
      if (ctl.flagBad) errReg <= 1'b1;
    end
  end

  assign wrSubch   = subReg;
  assign wrMethod  = methReg;
  assign errSticky = errReg;
endmodule

// File: rtl/cmdDecCtrl.sv
module cmdDecCtrl
  import cmdDecPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      inValid,
  input  logic      wrReady,
  input  hdrInfoT   hdr,
  output ctlStrobeT ctl,
  output logic      inReady,
  output logic      wrValid
);
  typedef enum logic {ST_HDR, ST_DATA} stateT;
  stateT            state;
  logic [CNT_W-1:0] remain;
  logic             inData;
  logic             hdrTake;

  always_comb begin
    inData      = (state == ST_DATA);
    wrValid     = inData && inValid;
    inReady     = inData ? wrReady : 1'b1;
    hdrTake     = !inData && inValid;
    ctl.loadHdr = hdrTake && !hdr.bad && (hdr.count != '0);
    ctl.flagBad = hdrTake && hdr.bad;
    ctl.advance = wrValid && wrReady;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_HDR;
      remain <= '0;
    end else if (ctl.loadHdr) begin
      state  <= ST_DATA;
      remain <= hdr.count;
    end else if (ctl.advance) begin
      remain <= remain - CNT_W'(1);
      if (remain == CNT_W'(1)) state <= ST_HDR;
    end
  end
endmodule

// File: rtl/cmdStreamDecoder.sv
module cmdStreamDecoder
  import cmdDecPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              newLayout,
  input  logic              inValid,
  output logic              inReady,
  input  logic [WORD_W-1:0] inWord,
  output logic              wrValid,
  input  logic              wrReady,
  output logic [SUB_W-1:0]  wrSubch,
  output logic [METH_W-1:0] wrMethod,
  output logic [WORD_W-1:0] wrData,
  output logic              errSticky
);
  ctlStrobeT ctl;
  hdrInfoT   hdr;

  cmdDecCtrl uCtrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .wrReady(wrReady),
    .hdr(hdr), .ctl(ctl), .inReady(inReady), .wrValid(wrValid)
  );

  cmdDecPath uPath (
    .clk(clk), .rstN(rstN), .newLayout(newLayout), .inWord(inWord),
    .ctl(ctl), .hdr(hdr), .wrSubch(wrSubch), .wrMethod(wrMethod),
    .errSticky(errSticky)
  );

  assign wrData = inWord;
endmodule

// File: rtl/cmdDecChecker.sv
module cmdDecChecker
  import cmdDecPkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic              inReady,
  input logic              wrValid,
  input logic              wrReady,
  input logic [SUB_W-1:0]  wrSubch,
  input logic [METH_W-1:0] wrMethod,
  input logic              errSticky
);
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    errSticky |=> errSticky); // R8
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && !wrReady) |=> ($stable(wrMethod) && $stable(wrSubch))); // R9
  AST_READY_TIED: assert property (@(posedge clk) disable iff (!rstN)
    wrValid |-> (inReady == wrReady)); // R9
  AST_WR_NEEDS_IN: assert property (@(posedge clk) disable iff (!rstN)
    wrValid |-> inValid); // R6
  AST_METH_ALIGN: assert property (@(posedge clk) disable iff (!rstN)
    wrValid |-> (wrMethod[1:0] == 2'b00)); // R2
  AST_METH_STEP: assert property (@(posedge clk) disable iff (!rstN)
    ($past(wrValid && wrReady) && wrValid) |->
      ((wrMethod == $past(wrMethod)) || (wrMethod == $past(wrMethod) + METH_W'(4)))); // R5
endmodule

bind cmdStreamDecoder cmdDecChecker uChk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
  .wrValid(wrValid), .wrReady(wrReady), .wrSubch(wrSubch),
  .wrMethod(wrMethod), .errSticky(errSticky)
);

// File: tb/tb_cmdStreamDecoder.sv
module tb_cmdStreamDecoder;
  logic        clk = 0;
  logic        rstN = 0;
  logic        newLayout = 0;
  logic        inValid = 0;
  logic        inReady;
  logic [31:0] inWord = '0;
  logic        wrValid;
  logic        wrReady = 0;
  logic [2:0]  wrSubch;
  logic [14:0] wrMethod;
  logic [31:0] wrData;
  logic        errSticky;
  int nChecks = 0;
  int nErr = 0;
  int seq = 0;

  always #10 clk = ~clk;

  cmdStreamDecoder dut (
    .clk(clk), .rstN(rstN), .newLayout(newLayout), .inValid(inValid),
    .inReady(inReady), .inWord(inWord), .wrValid(wrValid), .wrReady(wrReady),
    .wrSubch(wrSubch), .wrMethod(wrMethod), .wrData(wrData), .errSticky(errSticky)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic doReset(input logic nl);
    @(negedge clk);
    rstN = 0; newLayout = nl; inValid = 0; wrReady = 0;
    repeat (2) @(negedge clk);
    rstN = 1;
  endtask

  // stall: cycles wrReady is held low before the write is accepted
  task automatic sendWord(input logic [31:0] w, input bit expWr, input int expSub,
                          input int expMeth, input int stall, input string req);
    @(negedge clk);
    inValid = 1; inWord = w; wrReady = (stall == 0);
    #1;
    if (expWr) begin
      for (int s = 0; s < stall; s++) begin
        chk(wrValid == 1, {req, " stalled valid"}, wrValid, 1);
        chk(inReady == 0, "R9 ready low in stall", inReady, 0);
        chk(wrMethod == expMeth[14:0], "R9 method held", wrMethod, expMeth);
        @(negedge clk); #1;
      end
      wrReady = 1; #1;
      chk(wrValid == 1, {req, " write valid"}, wrValid, 1);
      chk(wrSubch == expSub[2:0], {req, " subch"}, wrSubch, expSub);
      chk(wrMethod == expMeth[14:0], {req, " method"}, wrMethod, expMeth);
      chk(wrData == w, "R6 data", wrData, w);
      chk(inReady == 1, "R9 ready when accepted", inReady, 1);
    end else begin
      chk(wrValid == 0, {req, " no write on header"}, wrValid, 0);
      chk(inReady == 1, "R9 header accepted", inReady, 1);
    end
    @(posedge clk); #1;
    inValid = 0; wrReady = 0;
  endtask

  // kind: 0 incrementing, 1 non-incrementing (older layout only)
  task automatic sendPacket(input logic nl, input int kind, input int sub,
                            input int meth, input int cnt, input string req);
    logic [31:0] h;
    int base;
    int m;
    if (!nl) begin
      h = (kind != 0 ? 32'h4000_0000 : 32'h0) | (32'(cnt) << 18) | (32'(sub) << 13) | 32'(meth & 'h1FFF);
      base = meth & 'h1FFC;
    end else begin
      h = 32'h2000_0000 | (32'(cnt) << 16) | (32'(sub) << 13) | 32'(meth & 'h1FFF);
      base = ((meth & 'h1FFF) << 2) & 'h7FFF;
    end
    sendWord(h, 0, 0, 0, cnt % 2, req);
    for (int k = 0; k < cnt; k++) begin
      m = (kind != 0) ? base : ((base + 4 * k) & 'h7FFF);
      seq++;
      sendWord(32'hA500_0000 ^ (32'(seq) * 32'h0101_0101), 1, sub, m,
               (k == 1) ? 2 : 0, (k > 0 && kind == 0) ? "R5" : req);
    end
    @(negedge clk); #1;
    chk(wrValid == 0 && inReady == 1, "R6 back to header", {wrValid, inReady}, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nErr++; nChecks++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end

  initial begin
    doReset(0);
    @(negedge clk); #1;
    chk(wrValid == 0, "R1 wrValid", wrValid, 0);
    chk(inReady == 1, "R1 inReady", inReady, 1);
    chk(errSticky == 0, "R1 errSticky", errSticky, 0);

    for (int nl = 0; nl < 2; nl++) begin
      doReset(nl[0]);
      for (int sub = 0; sub < 8; sub++)
        for (int cnt = 0; cnt < 5; cnt++)
          for (int kind = 0; kind < (nl == 0 ? 2 : 1); kind++)
            sendPacket(nl[0], kind, sub, sub * 'h1235 + cnt * 'h0F9 + kind * 'h41,
                       cnt, cnt == 0 ? "R7" : (nl == 1 ? "R4" : (kind == 1 ? "R3" : "R2")));
    end

    // wrap at top of 15-bit byte space, newer layout (R5)
    doReset(1);
    sendPacket(1, 0, 5, 'h1FFF, 3, "R5");
    sendPacket(1, 0, 6, 0, 1, "R4");
    // older layout: top address, low bits set (R2), bind handle on subch 6 (R3)
    doReset(0);
    sendPacket(0, 0, 3, 'h1FFF, 2, "R2");
    sendPacket(0, 1, 6, 0, 3, "R3");
    chk(errSticky == 0, "R8 no error on good headers", errSticky, 0);

    // malformed older header with nonzero count
    sendWord(32'h8000_0000 | (32'd2 << 18), 0, 0, 0, 0, "R8");
    chk(errSticky == 1, "R8 error set", errSticky, 1);
    sendPacket(0, 0, 2, 'h0100, 1, "R8");
    chk(errSticky == 1, "R8 error stays", errSticky, 1);
    sendWord(32'hC004_0000, 0, 0, 0, 0, "R8");
    doReset(0);
    @(negedge clk); #1;
    chk(errSticky == 0, "R1 error cleared by reset", errSticky, 0);

    // malformed newer header (pattern 010), count 1
    doReset(1);
    sendWord(32'h4001_0000, 0, 0, 0, 0, "R8");
    chk(errSticky == 1, "R8 newer error set", errSticky, 1);
    sendPacket(1, 0, 7, 'h0010, 2, "R8");

    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end
endmodule